// File: doc/BRIEF.md
# Programmable YUV to RGB Colour Converter

This block turns a stream of 8-bit luma/chroma triples into 8-bit red, green and blue samples. Each output colour comes from one row of a programmable 3x4 matrix: three signed gains, applied to Y, U and V, and an additive signed constant. Gains are 13-bit two's-complement values with 10 fractional bits. Constants are 14-bit two's-complement values with 4 fractional bits. Out of reset the matrix holds the BT.601 studio-range set, which maps Y in 16..235 and U/V in 16..240 onto full-range RGB 0..255.

Software writes coefficients through a simple write port into a staging copy. Both the staged coefficients and the requested bypass mode reach the datapath only on a frame-start pulse, so a frame never mixes two coefficient sets. In bypass mode the three input lanes pass straight through, which suits sources that are already RGB.

Both pixel interfaces use valid/ready handshakes. A transfer happens on a clock edge where valid and ready are both high. The input side is ready whenever the output register is empty or the consumer is taking its contents. While the output is stalled, the output holds its valid and its data.

Top module: `csc_yuv_rgb`

## Requirements
- R1: After reset, `m_valid` is 0, `s_ready` is 1 and the active matrix is the BT.601 set. With that set, input (16,128,128) gives R,G,B = (0,0,0) and input (235,128,128) gives (255,255,255).
- R2: Each channel equals floor(x + 0.5), where x = (gY*Y + gU*U + gV*V)/1024 + K/16. The gains g are signed 13-bit values and K is a signed 14-bit value.
- R3: A channel result below 0 is output as 0, and a result above 255 is output as 255.
- R4: Coefficient address = row*4 + column. Rows are G=0, R=1, B=2. Columns are gain-Y=0, gain-U=1, gain-V=2, constant=3. A gain is taken from `cfg_wdata[12:0]` and a constant from `cfg_wdata[13:0]`; all higher data bits are ignored.
- R5: A write lands in the staging copy only. The active matrix takes the staging contents on a `frame_start` edge. A write on that same edge waits for the next `frame_start`. A pixel accepted on the `frame_start` edge still uses the previous matrix.
- R6: Writes to addresses 12 to 15 change no coefficient.
- R7: `cfg_bypass` is sampled on `frame_start`. For pixels accepted while bypass is active, `m_r` = `s_y`, `m_g` = `s_u` and `m_b` = `s_v`.
- R8: With `m_ready` held high, a pixel accepted on edge E is presented with `m_valid` high after edge E+2, that is, a three-cycle latency.
- R9: While `m_valid` is 1 and `m_ready` is 0, `m_valid` and the data stay unchanged. Pixels are neither lost, duplicated nor reordered under any pattern of back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 4 | Coefficient index (row*4+column) |
| cfg_wdata | input | 32 | Coefficient write data |
| cfg_bypass | input | 1 | Requested pass-through mode, applied at frame start |
| frame_start | input | 1 | Pulse that commits staged coefficients and bypass |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Input pixel accepted when high with s_valid |
| s_y | input | 8 | Luma (R lane in bypass) |
| s_u | input | 8 | Blue-difference chroma (G lane in bypass) |
| s_v | input | 8 | Red-difference chroma (B lane in bypass) |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Consumer ready |
| m_r | output | 8 | Red |
| m_g | output | 8 | Green |
| m_b | output | 8 | Blue |

## Verification
The bench goes after the commit edge: it writes a coefficient on the same edge as `frame_start` and sends a pixel on that edge. A design that updated the active set too early would colour that pixel with the new matrix, and one that merged the concurrent write would apply it a frame too soon. The bench drives both saturation directions and half-way rounding cases, where a truncating or wrapping datapath gives values off by one or wrapped round. It writes data with garbage in the upper bits and writes to unused addresses, which catch bad field slicing or address decoding. Random back-pressure shows up any pipeline that drops, repeats or changes a stalled pixel.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int N_ROWS   = 3;
  localparam int N_TAPS   = 4;
  localparam int N_COEF   = N_ROWS * N_TAPS;
  localparam int MUL_W    = 13;
  localparam int MUL_FRAC = 10;
  localparam int OFS_W    = 14;
  localparam int OFS_FRAC = 4;
  localparam int SLOT_W   = (OFS_W > MUL_W) ? OFS_W : MUL_W;
  localparam int CFG_AW   = 4;
  localparam int ROW_G    = 0;
  localparam int ROW_R    = 1;
  localparam int ROW_B    = 2;

  // BT.601 studio range to full range RGB, rows G, R, B
  function automatic logic [SLOT_W-1:0] coef_default(input int idx);
    case (idx)
      0, 4, 8: return SLOT_W'(14'h04A7);
      1:       return SLOT_W'(14'h1E6F);
      2:       return SLOT_W'(14'h1CBF);
      3:       return SLOT_W'(14'h0877);
      6:       return SLOT_W'(14'h0662);
      7:       return SLOT_W'(14'h3211);
      9:       return SLOT_W'(14'h0812);
      11:      return SLOT_W'(14'h2EB1);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/csc_coef_bank.sv
module csc_coef_bank
  import csc_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [CFG_AW-1:0]             cfg_addr,
  input  logic [31:0]                   cfg_wdata,
  input  logic                          bypass_req,
  input  logic                          frame_start,
  output logic [N_COEF-1:0][SLOT_W-1:0] act_coef,
  output logic                          act_bypass
);
  generate
    for (genvar i = 0; i < N_COEF; i++) begin : g_slot
      localparam int FW = ((i % N_TAPS) == N_TAPS - 1) ? OFS_W : MUL_W;
      logic [SLOT_W-1:0] stage_q;
      logic [SLOT_W-1:0] live_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q <= coef_default(i);
          live_q  <= coef_default(i);
        end else begin
          if (frame_start)
            live_q <= stage_q;
          if (cfg_we && (cfg_addr == CFG_AW'(i)))
            stage_q <= SLOT_W'(cfg_wdata[FW-1:0]);
        end
      end

      assign act_coef[i] = live_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      act_bypass <= 1'b0;
    else if (frame_start)
      act_bypass <= bypass_req;
  end
endmodule

// File: rtl/csc_row.sv
module csc_row
  import csc_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  logic [N_TAPS-2:0][PIX_W-1:0]  pix,
  input  logic [N_TAPS-1:0][SLOT_W-1:0] coef,
  output logic [PIX_W-1:0]              res
);
  localparam int N_IN   = N_TAPS - 1;
  localparam int PROD_W = MUL_W + PIX_W + 1;
  localparam int ACC_W  = PROD_W + 2;
  localparam int ALIGN  = MUL_FRAC - OFS_FRAC;
  localparam int QW     = ACC_W - MUL_FRAC;
  localparam logic signed [QW-1:0] QMAX = QW'((1 << PIX_W) - 1);

  logic signed [PROD_W-1:0] mul_x  [N_IN];
  logic signed [PROD_W-1:0] pix_x  [N_IN];
  logic signed [PROD_W-1:0] prod_q [N_IN];
  logic signed [OFS_W-1:0]  ofs_q;
  logic signed [ACC_W-1:0]  sum_c, acc_q, rnd_c;
  logic signed [QW-1:0]     q_c;
  logic [PIX_W-1:0]         sat_c;

  generate
    for (genvar c = 0; c < N_IN; c++) begin : g_tap
      assign mul_x[c] = PROD_W'($signed(coef[c][MUL_W-1:0]));
      assign pix_x[c] = {{(PROD_W-PIX_W){1'b0}}, pix[c]};
    end
  endgenerate

  // stage 1: products and constant captured with the pixel
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < N_IN; c++) prod_q[c] <= '0;
      ofs_q <= '0;
    end else if (en) begin
      for (int c = 0; c < N_IN; c++) prod_q[c] <= mul_x[c] * pix_x[c];
      ofs_q <= $signed(coef[N_TAPS-1][OFS_W-1:0]);
    end
  end

  // stage 2: sum in gain fractional scale
  always_comb begin
    sum_c = ACC_W'(ofs_q) <<< ALIGN;
    for (int c = 0; c < N_IN; c++) sum_c = sum_c + ACC_W'(prod_q[c]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= sum_c;
  end

  // stage 3: round half up, clamp
  always_comb begin
    rnd_c = acc_q + ACC_W'(1 << (MUL_FRAC - 1));
    q_c   = QW'(rnd_c >>> MUL_FRAC);
    if (q_c < 0)         sat_c = '0;
    else if (q_c > QMAX) sat_c = '1;
    else                 sat_c = q_c[PIX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  res <= '0;
    else if (en) res <= sat_c;
  end
endmodule

// File: rtl/csc_yuv_rgb.sv
module csc_yuv_rgb
  import csc_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              cfg_bypass,
  input  logic              frame_start,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [PIX_W-1:0]  s_y,
  input  logic [PIX_W-1:0]  s_u,
  input  logic [PIX_W-1:0]  s_v,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [PIX_W-1:0]  m_r,
  output logic [PIX_W-1:0]  m_g,
  output logic [PIX_W-1:0]  m_b
);
  localparam int N_IN = N_TAPS - 1;

  logic [N_COEF-1:0][SLOT_W-1:0] act_coef;
  logic                          act_bypass;
  logic [N_IN-1:0][PIX_W-1:0]    pix_in, raw1, raw2, raw3;
  logic [N_ROWS-1:0][PIX_W-1:0]  row_res;
  logic                          adv;
  logic                          v1, v2, v3;
  logic                          b1, b2, b3;

  csc_coef_bank u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .bypass_req (cfg_bypass),
    .frame_start(frame_start),
    .act_coef   (act_coef),
    .act_bypass (act_bypass)
  );

  assign pix_in  = {s_v, s_u, s_y};
  assign adv     = !v3 || m_ready;
  assign s_ready = adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {v1, v2, v3} <= '0;
      {b1, b2, b3} <= '0;
    end else if (adv) begin
      v1 <= s_valid;
      v2 <= v1;
      v3 <= v2;
      b1 <= act_bypass;
      b2 <= b1;
      b3 <= b2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw1 <= '0;
      raw2 <= '0;
      raw3 <= '0;
    end else if (adv) begin
      raw1 <= pix_in;
      raw2 <= raw1;
      raw3 <= raw2;
    end
  end

  generate
    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
      csc_row #(.PIX_W(PIX_W)) u_row (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (adv),
        .pix  (pix_in),
        .coef (act_coef[r*N_TAPS +: N_TAPS]),
        .res  (row_res[r])
      );
    end
  endgenerate

  assign m_valid = v3;
  assign m_r = b3 ? raw3[0] : row_res[ROW_R];
  assign m_g = b3 ? raw3[1] : row_res[ROW_G];
  assign m_b = b3 ? raw3[2] : row_res[ROW_B];
endmodule

// File: rtl/csc_yuv_rgb_chk.sv
module csc_yuv_rgb_chk
  import csc_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          s_valid,
  input logic                          s_ready,
  input logic                          m_valid,
  input logic                          m_ready,
  input logic [PIX_W-1:0]              m_r,
  input logic [PIX_W-1:0]              m_g,
  input logic [PIX_W-1:0]              m_b,
  input logic                          frame_start,
  input logic [N_COEF-1:0][SLOT_W-1:0] act_coef,
  input logic                          act_bypass
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable({m_r, m_g, m_b})); // R9

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) ##1 m_ready ##1 m_ready |=> m_valid); // R8

  AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_valid && m_ready) ##1 (!s_valid && m_ready) ##1 (!s_valid && m_ready) |=> !m_valid); // R8

  AST_COEF_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(act_coef)); // R5

  AST_BYPASS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(act_bypass)); // R7
endmodule

bind csc_yuv_rgb csc_yuv_rgb_chk #(.PIX_W(PIX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .s_valid    (s_valid),
  .s_ready    (s_ready),
  .m_valid    (m_valid),
  .m_ready    (m_ready),
  .m_r        (m_r),
  .m_g        (m_g),
  .m_b        (m_b),
  .frame_start(frame_start),
  .act_coef   (act_coef),
  .act_bypass (act_bypass)
);

// File: tb/csc_yuv_rgb_test.sv
module csc_yuv_rgb_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_bypass = 1'b0;
  logic        frame_start = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [7:0]  s_y = '0, s_u = '0, s_v = '0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic [7:0]  m_r, m_g, m_b;

  csc_yuv_rgb uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_bypass(cfg_bypass), .frame_start(frame_start),
    .s_valid(s_valid), .s_ready(s_ready), .s_y(s_y), .s_u(s_u), .s_v(s_v),
    .m_valid(m_valid), .m_ready(m_ready), .m_r(m_r), .m_g(m_g), .m_b(m_b)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0, failures = 0;
  bit    finished = 0;
  string cur_req = "R2";
  int    shd [12];
  int    act [12];
  bit    act_byp = 0;
  int    expq [$];
  int    last_out = 0;
  bit    accepted = 0;
  bit    prev_hold = 0;
  int    held_val = 0;

  task automatic chk(input string req, input int actual, input int expected, input string what);
    checks++;
    if (actual !== expected) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, actual, expected);
    end
  endtask

  function automatic int sx(input int val, input int w);
    int m = val & ((1 << w) - 1);
    if (m >= (1 << (w - 1))) m = m - (1 << w);
    return m;
  endfunction

  function automatic int chan(input int row, input int y, input int u, input int v);
    int t, q;
    t = sx(act[row*4], 13) * y + sx(act[row*4+1], 13) * u + sx(act[row*4+2], 13) * v
        + sx(act[row*4+3], 14) * 64 + 512;
    if (t >= 0) q = t / 1024;
    else q = -((-t + 1023) / 1024);
    if (q < 0) q = 0;
    if (q > 255) q = 255;
    return q;
  endfunction

  function automatic int model_pix(input int y, input int u, input int v);
    if (act_byp) return (y << 16) | (u << 8) | v;
    return (chan(1, y, u, v) << 16) | (chan(0, y, u, v) << 8) | chan(2, y, u, v);
  endfunction

  // one clock: inputs already driven after a falling edge
  task automatic cycle();
    int got;
    #1;
    got = int'({m_r, m_g, m_b});
    if (prev_hold) begin
      chk("R9", int'(m_valid), 1, "valid dropped during stall");
      chk("R9", got, held_val, "data changed during stall");
    end
    prev_hold = m_valid && !m_ready;
    held_val = got;
    accepted = s_valid && s_ready;
    if (accepted) expq.push_back(model_pix(s_y, s_u, s_v));
    if (m_valid && m_ready) begin
      if (expq.size() == 0) chk(cur_req, 1, 0, "unexpected output pixel");
      else chk(cur_req, got, expq.pop_front(), "pixel");
      last_out = got;
    end
    if (frame_start) begin
      for (int i = 0; i < 12; i++) act[i] = shd[i];
      act_byp = cfg_bypass;
    end
    if (cfg_we && cfg_addr < 12)
      shd[cfg_addr] = (cfg_addr % 4 == 3) ? (cfg_wdata & 32'h3FFF) : (cfg_wdata & 32'h1FFF);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = d;
    cycle();
    cfg_we = 0;
  endtask

  task automatic commit();
    frame_start = 1;
    cycle();
    frame_start = 0;
  endtask

  task automatic push(input int y, input int u, input int v);
    s_valid = 1; s_y = 8'(y); s_u = 8'(u); s_v = 8'(v);
    do cycle(); while (!accepted);
    s_valid = 0;
  endtask

  task automatic drain();
    m_ready = 1; s_valid = 0;
    for (int i = 0; i < 20 && (expq.size() != 0 || m_valid); i++) cycle();
    chk(cur_req, expq.size(), 0, "pixels left undelivered");
  endtask

  task automatic pix1(input int y, input int u, input int v, input string req, input int expv);
    push(y, u, v);
    drain();
    chk(req, last_out, expv, "direct value");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 12; i++) shd[i] = 0;
    shd[0] = 'h4A7; shd[1] = 'h1E6F; shd[2] = 'h1CBF; shd[3] = 'h0877;
    shd[4] = 'h4A7; shd[6] = 'h662;  shd[7] = 'h3211;
    shd[8] = 'h4A7; shd[9] = 'h812;  shd[11] = 'h2EB1;
    for (int i = 0; i < 12; i++) act[i] = shd[i];
    repeat (3) @(negedge clk);
    chk("R1", int'(m_valid), 0, "m_valid in reset");
    rst_n = 1;
    @(negedge clk);
    chk("R1", int'(m_valid), 0, "m_valid after reset");
    chk("R1", int'(s_ready), 1, "s_ready after reset");

    // R1 defaults: black and white
    cur_req = "R1";
    pix1(16, 128, 128, "R1", 'h000000);
    pix1(235, 128, 128, "R1", 'hFFFFFF);

    // R3 saturation both ways with defaults
    cur_req = "R3";
    pix1(255, 255, 0, "R3", model_pix(255, 255, 0));
    pix1(0, 0, 255, "R3", model_pix(0, 0, 255));
    chk("R3", last_out & 'hFF00, 0, "green clamps to 0");

    // R8 latency: accept, then two quiet cycles, visible at the third
    cur_req = "R8";
    m_ready = 1;
    push(100, 90, 160);
    chk("R8", int'(m_valid), 0, "valid one cycle after accept");
    cycle();
    chk("R8", int'(m_valid), 0, "valid two cycles after accept");
    cycle();
    chk("R8", int'(m_valid), 1, "valid three cycles after accept");
    drain();

    // R4 field/row order, upper data bits ignored
    cur_req = "R4";
    for (int i = 0; i < 12; i++) wr(i, 32'hFFFF_0000);
    wr(0, 32'hFFFF_E400);   // G gain Y = 1.0
    wr(6, 32'h8000_0400);   // R gain V = 1.0
    wr(11, 32'hABCD_0640);  // B constant = 100.0
    for (int i = 1; i < 11; i++) if (i != 6) wr(i, 32'hFFFF_C000);
    wr(3, 32'hFFFF_C000);
    commit();
    pix1(17, 200, 60, "R4", (60 << 16) | (17 << 8) | 100);

    // R2 rounding half up: G gain Y 0.5, constant -0.5
    cur_req = "R2";
    wr(0, 'h200); wr(3, 'h3FF8);
    commit();
    pix1(3, 0, 0, "R2", (0 << 16) | (1 << 8) | 100);   // 1.5-0.5 = 1.0
    pix1(4, 0, 0, "R2", (0 << 16) | (2 << 8) | 100);   // 2.0-0.5 = 1.5 -> 2
    wr(3, 0);
    commit();
    pix1(3, 0, 0, "R2", (0 << 16) | (2 << 8) | 100);   // 1.5 -> 2

    // R5 staging: write without commit has no effect
    cur_req = "R5";
    wr(11, 'h0320);  // B constant 50 staged
    pix1(3, 0, 0, "R5", (0 << 16) | (2 << 8) | 100);
    // pixel on the commit edge uses old set; write on commit edge deferred
    cfg_we = 1; cfg_addr = 4'd7; cfg_wdata = 'h00A0;  // R constant 10 staged late
    frame_start = 1; s_valid = 1; s_y = 3; s_u = 0; s_v = 0;
    cycle();
    cfg_we = 0; frame_start = 0; s_valid = 0;
    drain();
    chk("R5", last_out, (0 << 16) | (2 << 8) | 100, "pixel on commit edge");
    pix1(3, 0, 0, "R5", (0 << 16) | (2 << 8) | 50);
    commit();
    pix1(3, 0, 0, "R5", (10 << 16) | (2 << 8) | 50);

    // R6 unused addresses
    cur_req = "R6";
    for (int a = 12; a < 16; a++) wr(a, 32'hFFFF_FFFF);
    commit();
    pix1(3, 0, 0, "R6", (10 << 16) | (2 << 8) | 50);

    // R2 random matrices and pixels against the model
    cur_req = "R2";
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 12; i++) wr(i, int'($urandom));
      commit();
      for (int p = 0; p < 30; p++) push($urandom % 256, $urandom % 256, $urandom % 256);
      drain();
    end

    // R7 bypass sampled only at commit
    cur_req = "R7";
    cfg_bypass = 1;
    pix1(10, 20, 30, "R7", model_pix(10, 20, 30));
    commit();
    cfg_bypass = 0;
    pix1(10, 20, 30, "R7", 'h0A141E);
    pix1(255, 0, 128, "R7", 'hFF0080);
    commit();
    pix1(235, 128, 128, "R7", model_pix(235, 128, 128));

    // R9 full stall then random back-pressure
    cur_req = "R9";
    m_ready = 0;
    for (int p = 0; p < 3; p++) push(40 + p, 90, 200);
    s_valid = 1; s_y = 77;
    cycle();
    chk("R9", int'(s_ready), 0, "s_ready with full pipeline and stall");
    chk("R9", int'(accepted), 0, "no accept while full");
    s_valid = 0;
    cycle();
    drain();
    begin
      int sent = 0;
      bit pend = 0;
      for (int c = 0; c < 3000 && sent < 200; c++) begin
        if (!pend || accepted) begin
          if (accepted) sent++;
          pend = ($urandom % 10) < 7;
          s_y = 8'($urandom); s_u = 8'($urandom); s_v = 8'($urandom);
        end
        if (sent >= 200) pend = 0;
        s_valid = pend;
        m_ready = ($urandom % 10) < 6;
        cycle();
      end
    end
    drain();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule